// File: doc/BRIEF.md
# Page-Mode ROM Emulator

This block is a clocked, synthesizable stand-in for the device side of a parallel read-only memory that supports page reads. On every clock edge it samples a word address, an address LSB used only for byte reads, an active-low chip select, an output-enable pin and a width-select pin. It reads a 16-bit word from an internal array whose contents are computed at build time. After a latency counted in clock cycles it presents that word, or one byte of it, on a 16-bit data bus. Two per-lane drive enables tell the surrounding pad logic which bits it may drive.

The latency depends on what changed. A move to another page, a change of width mode, or selecting the chip again costs the long random-access latency. A move within the current page costs only the short page latency. The block raises a data-valid flag when the data on the bus is settled. The polarity of the output-enable pin is fixed at build time. It can be active low, active high, or ignored, in which case the chip select alone gates the lanes.

Top module: `pgrom_emu`

## Requirements
- R1: With `word_mode_i` = 1 and `valid_o` high, `data_o` equals the stored word at `addr_i`. The word stored at address a, taking b = a mod 256, is {b XOR 8'h5A, (3*b + 17) mod 256}, upper byte first.
- R2: With `word_mode_i` = 0 (byte mode), `lane_hi_en_o` is low and `data_o[15:8]` is zero. When valid, `data_o[7:0]` is the low byte of the stored word if `byte_lsb_i` = 0 and the high byte if it is 1.
- R3: After an edge that samples `ce_n_i` = 1, both lane enables and `valid_o` are low, whatever the value of `oe_i`.
- R4: Lane enables follow `oe_i` according to `OE_OPT`. With `OE_ACT_LOW` (the default) the lanes are on only when `oe_i` = 0. With `OE_ACT_HIGH` they are on only when `oe_i` = 1. With `OE_IGNORE`, `oe_i` has no effect.
- R5: Certain events are a full change: a change of any `addr_i` bit above the page field, a change of `word_mode_i`, or `ce_n_i` falling. After the edge that samples a full change, `valid_o` is low for `RAND_LAT` cycles (default 4) and high in the next cycle.
- R6: A page change alters only the low `PAGE_W` address bits (default 2), plus `byte_lsb_i` in byte mode. After the edge that samples a page change, `valid_o` is low for `PAGE_LAT` cycles (default 1) and then high.
- R7: In word mode a change of `byte_lsb_i` has no effect: `valid_o` stays high and `data_o` is unchanged.
- R8: Whenever `valid_o` is low, `data_o` is zero.
- R9: A rise of `ce_n_i`, or a move of `oe_i` to its inactive level, turns the lane enables off at the first clock edge that samples it.
- R10: While `rst_n` is low, `valid_o`, both lane enables and `data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address; low PAGE_W bits form the page field |
| byte_lsb_i | input | 1 | Byte-select address LSB, used in byte mode only |
| ce_n_i | input | 1 | Chip select, active low |
| oe_i | input | 1 | Output-enable pin, meaning set by OE_OPT |
| word_mode_i | input | 1 | 1 = 16-bit word reads, 0 = 8-bit byte reads |
| data_o | output | 16 | Read data, zero while not valid |
| lane_lo_en_o | output | 1 | Drive enable for data bits 7..0 |
| lane_hi_en_o | output | 1 | Drive enable for data bits 15..8 |
| valid_o | output | 1 | Read data settled for the current address |

## Verification
The assertions assume that inputs change only between clock edges and hold a single value across each sampling edge. They also assume `ADDR_W` is larger than `PAGE_W` and `RAND_LAT` is at least 1, so that every full change costs at least one cycle. The bench drives all inputs on the falling clock edge and samples results one falling edge later, which keeps each change inside one sampling window. Three instances run in parallel on shared inputs, one for each output-enable option, so a single stimulus stream exercises every polarity rule.

// File: rtl/pgrom_pkg.sv
package pgrom_pkg;

  // Build-time meaning of the output-enable pin
  typedef enum logic [1:0] {
    OE_ACT_LOW  = 2'd0,
    OE_ACT_HIGH = 2'd1,
    OE_IGNORE   = 2'd2
  } oe_opt_e;

  // Computed contents of the array: depends on the low 8 address bits
  function automatic logic [15:0] rom_word(logic [31:0] a);
    logic [7:0] b;
    b = a[7:0];
    return {b ^ 8'h5A, b * 8'd3 + 8'd17};
  endfunction

  // Byte steering for byte-wide reads
  function automatic logic [7:0] pick_byte(logic [15:0] w, logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction

endpackage

// File: rtl/pgrom_array.sv
module pgrom_array #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [15:0]       word_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign rom[i] = pgrom_pkg::rom_word(32'(i));
  end

  assign word_o = rom[addr_i];
endmodule

// File: rtl/pgrom_access_timer.sv
module pgrom_access_timer #(
  parameter int ADDR_W   = 8,
  parameter int PAGE_W   = 2,
  parameter int RAND_LAT = 4,
  parameter int PAGE_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lsb_i,
  input  logic              word_i,
  input  logic              ce_act_i,
  output logic [ADDR_W-1:0] s_addr_o,
  output logic              s_lsb_o,
  output logic              s_word_o,
  output logic              s_ce_o,
  output logic              ready_o,
  output logic              full_chg_o,
  output logic              page_chg_o
);
  localparam int MAX_LAT = (RAND_LAT > PAGE_LAT) ? RAND_LAT : PAGE_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic upper_diff, mode_diff, ce_rise, pfield_diff, lsb_diff;

  assign upper_diff  = addr_i[ADDR_W-1:PAGE_W] != s_addr_o[ADDR_W-1:PAGE_W];
  assign pfield_diff = addr_i[PAGE_W-1:0] != s_addr_o[PAGE_W-1:0];
  assign lsb_diff    = !word_i && (lsb_i != s_lsb_o);
  assign mode_diff   = word_i != s_word_o;
  assign ce_rise     = ce_act_i && !s_ce_o;

  assign full_chg_o = upper_diff || mode_diff || ce_rise;
  assign page_chg_o = pfield_diff || lsb_diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_addr_o <= '0;
      s_lsb_o  <= 1'b0;
      s_word_o <= 1'b1;
      s_ce_o   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      s_addr_o <= addr_i;
      s_lsb_o  <= lsb_i;
      s_word_o <= word_i;
      s_ce_o   <= ce_act_i;
      if (full_chg_o)
        cnt_q <= CNT_W'(RAND_LAT);
      else if (page_chg_o)
        cnt_q <= CNT_W'(PAGE_LAT);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/pgrom_lane_steer.sv
module pgrom_lane_steer #(
  parameter pgrom_pkg::oe_opt_e OE_OPT = pgrom_pkg::OE_ACT_LOW
) (
  input  logic [15:0] mem_word_i,
  input  logic        word_i,
  input  logic        lsb_i,
  input  logic        valid_i,
  input  logic        ce_i,
  input  logic        oe_pin_i,
  output logic [15:0] data_o,
  output logic        lo_en_o,
  output logic        hi_en_o
);
  logic oe_ok;

  if (OE_OPT == pgrom_pkg::OE_IGNORE) begin : g_oe_ign
    logic unused_pin;
    assign unused_pin = oe_pin_i;
    assign oe_ok = 1'b1;
  end else if (OE_OPT == pgrom_pkg::OE_ACT_HIGH) begin : g_oe_hi
    assign oe_ok = oe_pin_i;
  end else begin : g_oe_lo
    assign oe_ok = !oe_pin_i;
  end

  always_comb begin
    data_o = '0;
    if (valid_i)
      data_o = word_i ? mem_word_i
                      : {8'h00, pgrom_pkg::pick_byte(mem_word_i, lsb_i)};
  end

  assign lo_en_o = ce_i && oe_ok;
  assign hi_en_o = lo_en_o && word_i;
endmodule

// File: rtl/pgrom_emu.sv
module pgrom_emu #(
  parameter int ADDR_W   = 8,
  parameter int PAGE_W   = 2,
  parameter int RAND_LAT = 4,
  parameter int PAGE_LAT = 1,
  parameter pgrom_pkg::oe_opt_e OE_OPT = pgrom_pkg::OE_ACT_LOW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_lsb_i,
  input  logic              ce_n_i,
  input  logic              oe_i,
  input  logic              word_mode_i,
  output logic [15:0]       data_o,
  output logic              lane_lo_en_o,
  output logic              lane_hi_en_o,
  output logic              valid_o
);
  logic [ADDR_W-1:0] s_addr;
  logic s_lsb, s_word, s_ce, s_oe, rdy;
  logic full_chg_w, page_chg_w;
  logic [15:0] mem_word;

  // Output-enable pin is sampled like the other controls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_oe <= 1'b0;
    else        s_oe <= oe_i;
  end

  pgrom_access_timer #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .RAND_LAT(RAND_LAT), .PAGE_LAT(PAGE_LAT)
  ) timer_i (
    .clk(clk), .rst_n(rst_n),
    .addr_i(addr_i), .lsb_i(byte_lsb_i), .word_i(word_mode_i),
    .ce_act_i(!ce_n_i),
    .s_addr_o(s_addr), .s_lsb_o(s_lsb), .s_word_o(s_word), .s_ce_o(s_ce),
    .ready_o(rdy), .full_chg_o(full_chg_w), .page_chg_o(page_chg_w)
  );

  pgrom_array #(.ADDR_W(ADDR_W)) array_i (
    .addr_i(s_addr), .word_o(mem_word)
  );

  assign valid_o = s_ce && rdy;

  pgrom_lane_steer #(.OE_OPT(OE_OPT)) steer_i (
    .mem_word_i(mem_word), .word_i(s_word), .lsb_i(s_lsb),
    .valid_i(valid_o), .ce_i(s_ce), .oe_pin_i(s_oe),
    .data_o(data_o), .lo_en_o(lane_lo_en_o), .hi_en_o(lane_hi_en_o)
  );
endmodule

// File: rtl/pgrom_emu_chk.sv
module pgrom_emu_chk #(
  parameter int PAGE_LAT = 1,
  parameter pgrom_pkg::oe_opt_e OE_OPT = pgrom_pkg::OE_ACT_LOW
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n_i,
  input logic        oe_i,
  input logic        word_mode_i,
  input logic [15:0] data_o,
  input logic        lane_lo_en_o,
  input logic        lane_hi_en_o,
  input logic        valid_o,
  input logic        full_chg_w,
  input logic        page_chg_w
);
  // R3
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n_i) |-> (!lane_lo_en_o && !lane_hi_en_o && !valid_o));

  // R2
  byte_upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!word_mode_i) |-> (!lane_hi_en_o && data_o[15:8] == 8'h00));

  // R8
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> data_o == 16'h0000);

  // R5
  full_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(full_chg_w) |-> !valid_o);

  // R6
  page_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(page_chg_w && !full_chg_w) && PAGE_LAT > 0) |-> !valid_o);

  // R4
  oe_low_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (OE_OPT == pgrom_pkg::OE_ACT_LOW && $past(oe_i)) |-> !lane_lo_en_o);

  // R4
  oe_high_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (OE_OPT == pgrom_pkg::OE_ACT_HIGH && !$past(oe_i)) |-> !lane_lo_en_o);

  // R4
  oe_ignore_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (OE_OPT == pgrom_pkg::OE_IGNORE && $past(rst_n) && !$past(ce_n_i))
      |-> lane_lo_en_o);
endmodule

bind pgrom_emu pgrom_emu_chk #(.PAGE_LAT(PAGE_LAT), .OE_OPT(OE_OPT)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_i(oe_i),
  .word_mode_i(word_mode_i), .data_o(data_o),
  .lane_lo_en_o(lane_lo_en_o), .lane_hi_en_o(lane_hi_en_o),
  .valid_o(valid_o), .full_chg_w(full_chg_w), .page_chg_w(page_chg_w)
);

// File: tb/pgrom_emu_tb_top.sv
module pgrom_emu_tb_top;
  localparam int RLAT = 4;
  localparam int PLAT = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [7:0] addr;
  logic       lsb, ce_n, oe, wmode;
  logic [15:0] data;
  logic lo_en, hi_en, valid;
  logic [15:0] h_data, d_data;
  logic h_lo, h_hi, h_valid, d_lo, d_hi, d_valid;

  int n_chk = 0;
  int n_fail = 0;

  pgrom_emu dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .byte_lsb_i(lsb),
    .ce_n_i(ce_n), .oe_i(oe), .word_mode_i(wmode),
    .data_o(data), .lane_lo_en_o(lo_en), .lane_hi_en_o(hi_en), .valid_o(valid)
  );

  pgrom_emu #(.OE_OPT(pgrom_pkg::OE_ACT_HIGH)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .byte_lsb_i(lsb),
    .ce_n_i(ce_n), .oe_i(oe), .word_mode_i(wmode),
    .data_o(h_data), .lane_lo_en_o(h_lo), .lane_hi_en_o(h_hi), .valid_o(h_valid)
  );

  pgrom_emu #(.OE_OPT(pgrom_pkg::OE_IGNORE)) dut_dc_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .byte_lsb_i(lsb),
    .ce_n_i(ce_n), .oe_i(oe), .word_mode_i(wmode),
    .data_o(d_data), .lane_lo_en_o(d_lo), .lane_hi_en_o(d_hi), .valid_o(d_valid)
  );

  // Stored word restated: high = a xor 5A, low = 3a + 17 modulo 256
  function automatic logic [15:0] exp_word(int a);
    int lo;
    lo = ((a << 1) + a + 17) % 256;
    return {8'(a) ^ 8'b0101_1010, 8'(lo)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(logic [7:0] a, logic l, logic w, logic c, logic o);
    addr = a; lsb = l; wmode = w; ce_n = c; oe = o;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset();
    wait_n(3);
    chk("R10 valid", valid, 0);
    chk("R10 lo_en", lo_en, 0);
    chk("R10 hi_en", hi_en, 0);
    chk("R10 data", data, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_word_read();
    apply(8'h40, 0, 1, 0, 0);
    wait_n(RLAT);
    chk("R5 valid low during random access", valid, 0);
    chk("R8 data zero while invalid", data, 0);
    wait_n(1);
    chk("R5 valid after random latency", valid, 1);
    chk("R1 word data 0x40", data, exp_word(8'h40));
    chk("R1 both lanes on", {lo_en, hi_en}, 2'b11);
  endtask

  task automatic t_page();
    apply(8'h43, 0, 1, 0, 0);
    wait_n(PLAT);
    chk("R6 valid low in page access", valid, 0);
    wait_n(1);
    chk("R6 valid after page latency", valid, 1);
    chk("R1 word data 0x43", data, exp_word(8'h43));
  endtask

  task automatic t_upper();
    apply(8'h47, 0, 1, 0, 0);
    wait_n(RLAT);
    chk("R5 upper change keeps valid low", valid, 0);
    wait_n(1);
    chk("R5 upper change valid", valid, 1);
    chk("R1 word data 0x47", data, exp_word(8'h47));
  endtask

  task automatic t_byte();
    logic [15:0] w;
    w = exp_word(8'h47);
    apply(8'h47, 0, 0, 0, 0);
    wait_n(RLAT);
    chk("R5 mode change keeps valid low", valid, 0);
    wait_n(1);
    chk("R2 byte low data", data, {8'h00, w[7:0]});
    chk("R2 hi lane off, lo on", {lo_en, hi_en}, 2'b10);
    apply(8'h47, 1, 0, 0, 0);
    wait_n(PLAT);
    chk("R6 byte lsb change is page access", valid, 0);
    wait_n(1);
    chk("R2 byte high data", data, {8'h00, w[15:8]});
    w = exp_word(8'h45);
    apply(8'h45, 1, 0, 0, 0);
    wait_n(PLAT + 1);
    chk("R6 byte page move valid", valid, 1);
    chk("R2 byte high data 0x45", data, {8'h00, w[15:8]});
  endtask

  task automatic t_word_lsb();
    apply(8'h45, 1, 1, 0, 0);
    wait_n(RLAT + 1);
    chk("R1 back to word data", data, exp_word(8'h45));
    apply(8'h45, 0, 1, 0, 0);
    wait_n(1);
    chk("R7 lsb ignored valid", valid, 1);
    chk("R7 lsb ignored data", data, exp_word(8'h45));
    wait_n(1);
    chk("R7 lsb ignored data later", data, exp_word(8'h45));
  endtask

  task automatic t_oe();
    apply(8'h45, 0, 1, 0, 1);
    wait_n(1);
    chk("R9 oe off removes lanes (low opt)", {lo_en, hi_en}, 2'b00);
    chk("R4 high opt on", {h_lo, h_hi}, 2'b11);
    chk("R4 ignore opt on", {d_lo, d_hi}, 2'b11);
    chk("R4 oe does not restart access", valid, 1);
    apply(8'h45, 0, 1, 0, 0);
    wait_n(1);
    chk("R4 low opt on", {lo_en, hi_en}, 2'b11);
    chk("R4 high opt off", {h_lo, h_hi}, 2'b00);
    chk("R4 ignore opt still on", {d_lo, d_hi}, 2'b11);
  endtask

  task automatic t_ce();
    apply(8'h45, 0, 1, 1, 0);
    wait_n(1);
    chk("R3 deselect lanes low opt", {lo_en, hi_en, valid}, 3'b000);
    chk("R3 deselect ignore opt", {d_lo, d_hi}, 2'b00);
    apply(8'h45, 0, 1, 1, 1);
    wait_n(1);
    chk("R3 deselect high opt", {h_lo, h_hi}, 2'b00);
    chk("R8 deselect data zero", data, 0);
    apply(8'h45, 0, 1, 0, 0);
    wait_n(RLAT);
    chk("R5 reselect keeps valid low", valid, 0);
    wait_n(1);
    chk("R5 reselect valid", valid, 1);
    chk("R1 reselect data", data, exp_word(8'h45));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (R1..): actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    apply(8'h00, 0, 1, 1, 1);
    t_reset();
    t_word_read();
    t_page();
    t_upper();
    t_byte();
    t_word_lsb();
    t_oe();
    t_ce();
    finish_run();
  end
endmodule